// File: doc/BRIEF.md
# PRBS Receive Checker with Pattern Lock and Error Tally

This block sits behind one transceiver receive channel and judges a 20-bit pseudo-random test pattern. It first hunts the incoming word stream for the pattern's opening word. Once that word is seen, the block declares lock and starts a local reference generator. From then on, every accepted word is compared with the reference.

Four status outputs come out of the comparison. A lock flag shows that alignment has been reached. A per-word match bit shows whether the last compared word was correct. A sticky error flag records that at least one word was wrong since reset. A saturating counter holds the number of wrong words and can drive a numeric display.

The reference is built from twenty independent 5-bit shift registers, one per bit lane. Each register is seeded so that the first word of the pattern equals the sync word, and the pattern repeats every 31 words. A synchronous reset returns the block to the hunting state.

Top module: `prbs_rx_checker`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four outputs are cleared. After that edge, `data_valid`, `match` and `err_flag` are 0 and `err_cnt` is 0.
- R2: Before lock, any accepted word other than the sync word 20'h695A7 has no effect. All outputs stay 0 and no error is counted.
- R3: An accepted word equal to 20'h695A7 while unlocked raises `data_valid` one cycle later. `data_valid` then stays high until reset, including when later words are wrong or equal the sync word again.
- R4: The reference pattern is defined per bit lane. Bit i of every word comes from its own 5-bit register. That register starts at {SYNC bit i, 4-bit value ((i mod 15)+1)} and advances from s to {s[3:0], s[4]^s[2]}. The word bit is bit 4 of the register. The sync word is step 0. The n-th accepted word after it is compared with step n (mod 31).
- R5: After each accepted word while locked, `match` is 1 on the next cycle if the word equals the reference word and 0 if it does not.
- R6: A cycle with `rx_valid` low does not advance the reference and leaves `match`, `err_flag` and `err_cnt` unchanged.
- R7: Each accepted word that differs from the reference while locked raises `err_cnt` by exactly one. The new value appears one cycle later.
- R8: `err_flag` is set by the first mismatching word and stays set until reset.
- R9: `err_cnt` saturates at 2^CNT_W-1 (16'hFFFF by default) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | DATA_W (20) | Recovered receive word |
| rx_valid | input | 1 | High when `rx_data` carries a word |
| data_valid | output | 1 | Lock reached; comparison active |
| match | output | 1 | Last compared word was correct |
| err_flag | output | 1 | Sticky: a wrong word was seen since reset |
| err_cnt | output | CNT_W (16) | Saturating count of wrong words |

## Verification
The bound assertions check on every cycle the rules that hold for any stimulus:
- outputs stay quiet before lock;
- lock and the error flag never drop without reset;
- the counter only ever steps up by one and holds at its ceiling;
- a nonzero count always comes with the flag set.

Whether the reference really follows the lane recurrence, survives idle gaps and wraps after 31 words can only be shown by the bench scenarios. The same holds for whether each single corrupted word counts exactly once. Those scenarios feed pattern streams with random gaps, isolated corruptions, a mid-run reset and a long run into saturation.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
  localparam int LANE_W = 5;

  // One step of a lane register: x^5 + x^3 + 1, shifting toward the MSB
  function automatic logic [LANE_W-1:0] lane_step(input logic [LANE_W-1:0] s);
    return {s[3:0], s[4] ^ s[2]};
  endfunction

  // Start value of lane i: top bit carries the sync word bit, low bits nonzero
  function automatic logic [LANE_W-1:0] lane_seed(input logic sync_bit, input int lane);
    logic [3:0] low;
    low = 4'((lane % 15) + 1);
    return {sync_bit, low};
  endfunction
endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
  import prbs_chk_pkg::*;
#(
  parameter int          DATA_W    = 20,
  parameter logic [DATA_W-1:0] SYNC_WORD = 20'h695A7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  output logic [DATA_W-1:0] exp_word
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    localparam logic [LANE_W-1:0] SEED = lane_seed(SYNC_WORD[g], g);
    logic [LANE_W-1:0] st;

    always_ff @(posedge clk) begin
      if (rst)       st <= SEED;
      else if (load) st <= lane_step(SEED);   // word after the sync word
      else if (adv)  st <= lane_step(st);
    end

    assign exp_word[g] = st[LANE_W-1];
  end
endmodule

// File: rtl/sat_err_counter.sv
module sat_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/prbs_rx_checker.sv
module prbs_rx_checker #(
  parameter int                DATA_W    = 20,
  parameter int                CNT_W     = 16,
  parameter logic [DATA_W-1:0] SYNC_WORD = 20'h695A7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              data_valid,
  output logic              match,
  output logic              err_flag,
  output logic [CNT_W-1:0]  err_cnt
);
  logic              locked_q;
  logic              match_q;
  logic              flag_q;
  logic [DATA_W-1:0] ref_word;
  logic              sync_hit;
  logic              cmp_en;
  logic              word_bad;

  assign sync_hit = rx_valid && !locked_q && (rx_data == SYNC_WORD);
  assign cmp_en   = rx_valid && locked_q;
  assign word_bad = cmp_en && (rx_data != ref_word);

  prbs_ref_gen #(.DATA_W(DATA_W), .SYNC_WORD(SYNC_WORD)) u_ref (
    .clk      (clk),
    .rst      (rst),
    .load     (sync_hit),
    .adv      (cmp_en),
    .exp_word (ref_word)
  );

  sat_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .inc (word_bad),
    .cnt (err_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      match_q  <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (sync_hit) locked_q <= 1'b1;
      if (cmp_en)   match_q  <= !word_bad;
      if (word_bad) flag_q   <= 1'b1;
    end
  end

  assign data_valid = locked_q;
  assign match      = match_q;
  assign err_flag   = flag_q;
endmodule

// File: rtl/prbs_rx_checker_sva.sv
module prbs_rx_checker_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             data_valid,
  input logic             match,
  input logic             err_flag,
  input logic [CNT_W-1:0] err_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    !data_valid |-> (!match && !err_flag && err_cnt == '0)); // R2

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> data_valid); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(err_cnt) |-> (err_cnt == CNT_W'($past(err_cnt) + 1'b1))); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ($past(err_cnt) == CNT_MAX) |-> (err_cnt == CNT_MAX)); // R9

  AST_COUNT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (err_cnt != '0) |-> err_flag); // R8
endmodule

bind prbs_rx_checker prbs_rx_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .data_valid (data_valid),
  .match      (match),
  .err_flag   (err_flag),
  .err_cnt    (err_cnt)
);

// File: tb/prbs_rx_checker_tb.sv
module prbs_rx_checker_tb;
  localparam logic [19:0] SYNC = 20'h695A7;
  localparam logic [15:0] CMAX = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        data_valid, match, err_flag;
  logic [15:0] err_cnt;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;
  int ph;                 // step index of the next expected word
  logic [15:0] e_cnt;
  logic        e_flag;

  always #4 clk = ~clk;

  prbs_rx_checker u_dut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .data_valid(data_valid), .match(match), .err_flag(err_flag), .err_cnt(err_cnt)
  );

  // Reference word at step n, built from the lane rule of R4
  function automatic logic [19:0] ref_word(int n);
    logic [19:0] w;
    for (int i = 0; i < 20; i++) begin
      logic [4:0] s;
      s = {SYNC[i], 4'((i % 15) + 1)};
      for (int k = 0; k < n % 31; k++) s = {s[3:0], s[4] ^ s[2]};
      w[i] = s[4];
    end
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge; outputs settle by the next falling edge
  task automatic cyc(logic [19:0] w, logic v);
    rx_data = w; rx_valid = v;
    @(negedge clk);
  endtask

  task automatic chk_all(string req, logic dv, logic m);
    chk({req, " data_valid"}, 32'(data_valid), 32'(dv));
    chk({req, " match"}, 32'(match), 32'(m));
    chk({req, " err_flag"}, 32'(err_flag), 32'(e_flag));
    chk({req, " err_cnt"}, 32'(err_cnt), 32'(e_cnt));
  endtask

  task automatic do_reset();
    rst = 1'b1; rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    e_cnt = '0; e_flag = 1'b0;
  endtask

  // send locked words: good or corrupted, with an optional idle gap before it
  task automatic send_locked(bit corrupt, bit gap);
    logic [19:0] w;
    logic        m_before;
    if (gap) begin
      m_before = match;
      cyc($urandom, 1'b0);
      chk("R6 idle hold", {30'd0, match, err_flag}, {30'd0, m_before, e_flag});
    end
    w = ref_word(ph);
    if (corrupt) w = w ^ (20'($urandom) | 20'h1);
    cyc(w, 1'b1);
    ph++;
    if (corrupt) begin
      e_flag = 1'b1;
      if (e_cnt != CMAX) e_cnt++;
    end
    chk_all(corrupt ? "R7" : "R5", 1'b1, !corrupt);
  endtask

  task automatic hunt_and_lock();
    for (int i = 0; i < 6; i++) begin
      logic [19:0] w;
      w = $urandom;
      if (w == SYNC) w = w ^ 20'h1;
      cyc(w, 1'($urandom % 2));
      chk_all("R2", 1'b0, 1'b0);
    end
    cyc(SYNC, 1'b0);                  // sync with no strobe is not a word
    chk_all("R2", 1'b0, 1'b0);
    cyc(SYNC, 1'b1);
    chk_all("R3", 1'b1, 1'b0);
    ph = 1;
  endtask

  initial begin
    void'($urandom(32'd1337));
    e_cnt = '0; e_flag = 1'b0; ph = 0;
    @(negedge clk);
    do_reset();
    chk_all("R1", 1'b0, 1'b0);

    // directed: first words of the pattern, then full wrap past 31
    chk("R4 step0", 32'(ref_word(0)), 32'(SYNC));
    hunt_and_lock();
    for (int i = 0; i < 40; i++) send_locked(1'b0, 1'($urandom % 3 == 0));

    // random single-word corruptions
    for (int i = 0; i < 120; i++) send_locked(($urandom % 6) == 0, 1'($urandom % 4 == 0));

    // a sync word after lock is just another word: counted if wrong
    if (ref_word(ph) != SYNC) begin
      cyc(SYNC, 1'b1); ph++;
      e_flag = 1'b1; e_cnt++;
      chk_all("R3 relock ignored", 1'b1, 1'b0);
    end
    send_locked(1'b0, 1'b0);
    chk("R8 sticky", 32'(err_flag), 32'd1);

    // reset mid-run clears everything; relock
    do_reset();
    chk_all("R1 mid-run", 1'b0, 1'b0);
    hunt_and_lock();
    send_locked(1'b1, 1'b0);
    send_locked(1'b0, 1'b0);

    // saturation
    for (int i = 0; i < 65540; i++) begin
      cyc(ref_word(ph) ^ 20'h80, 1'b1);
      ph++;
    end
    chk("R9 saturated", 32'(err_cnt), 32'(CMAX));
    chk("R9 flag", 32'(err_flag), 32'd1);
    e_cnt = CMAX; e_flag = 1'b1;
    send_locked(1'b1, 1'b0);
    send_locked(1'b0, 1'b0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      nbad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule